// File: doc/BRIEF.md
# Temperature Monitor Interrupt Controller

This block runs a single temperature conversion each time the host asks for one. It turns the result into interrupt status. The host starts a conversion by writing to a control register. The block then asks an external converter for one sample and accepts the 8-bit result over a small valid/ready stream. It stores the sample in a readout register and sets a conversion-complete flag, which the host can either poll or take as an interrupt.

Every accepted sample is evaluated three ways:
- It is compared with a stored baseline, to detect a temperature swing.
- It is compared with an upper limit, to detect an over-temperature condition.
- It is compared with a lower limit, to detect an under-temperature condition.

The event bits (conversion done, swing, timeout) are sticky and clear when the host reads the status register. The over- and under-temperature bits always follow the latest sample, so the host can poll them with their interrupts masked until the panel is back in range. The active-low interrupt pin is the OR of all enabled status bits.

The converter stream has these rules. `adc_ready` is high only while a conversion is outstanding. The converter must hold `adc_valid` and `adc_data` stable until a cycle in which `adc_ready` is also high, and that cycle is the transfer. Samples offered while `adc_ready` is low are never taken. The host register port is plain: writes take effect at the clock edge, and read data appears one cycle after the read strobe.

Top module: `tmon_ctrl`

## Requirements
- R1: After reset `irq_n` is 1 and `adc_start` and `adc_ready` are 0. The registers read as follows: interrupt enables (0x05) = EN_RST, upper limit (0x10) = HOT_DEF, lower limit (0x11) = COLD_DEF, swing threshold (0x12) = DELTA_DEF, control (0x0D) = 0.
- R2: A write to control (0x0D) with bit 7 set, while idle, starts a conversion. `adc_start` pulses for one cycle and `adc_ready` rises in the same cycle. Control bit 7 (busy) reads 1 and control bit 5 (conversion-end) is cleared.
- R3: A sample transfers in the cycle where `adc_valid` and `adc_ready` are both high. `adc_ready` falls in the next cycle.
- R4: After a transfer, the readout register (0x00) holds the sample, control bit 5 reads 1 and status bit 0 (end of conversion) is set.
- R5: The first sample after reset, or after a control write with bit 6 set (re-arm), becomes the baseline and raises no swing. Status bit 1 (swing) is set when |sample − baseline| ≥ threshold, treating both as signed 8-bit values. The baseline is reloaded with the sample on every swing.
- R6: Status bit 2 (hot) is set when the sample is greater than the signed upper limit. Status bit 3 (cold) is set when the sample is less than the signed lower limit. Both are re-evaluated on every sample whatever the enables say.
- R7: The status register (0x07) reads the five status bits in bits 4..0. A status read clears bits 0, 1 and 4, and leaves hot and cold as they are.
- R8: `irq_n` is low exactly when some status bit is set whose enable bit (same position in 0x05) is set. Clearing an enable releases the pin while the condition persists.
- R9: A start request made while a conversion is outstanding is ignored and does not restart the wait.
- R10: If no transfer happens within TIMEOUT_CYC cycles of the start, the conversion is abandoned. `adc_ready` falls, status bit 4 (error) is set and the readout register is left unchanged.
- R11: Read data is registered: it is valid the cycle after `reg_rd_en`. Unmapped addresses read 0. Writes to the readout and status registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, one cycle after the strobe |
| adc_start | output | 1 | One-cycle conversion request to the converter |
| adc_ready | output | 1 | Block accepts a sample |
| adc_valid | input | 1 | Converter offers a sample |
| adc_data | input | 8 | Sample, signed degrees |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with TIMEOUT_CYC set to 16, so an abandoned conversion completes within a few register accesses. In that window the bench can tell an ignored second start from one that wrongly restarts the wait. HOT_DEF is set to 40, while COLD_DEF stays at −5 and DELTA_DEF at 2. With these values, swings of exactly one and exactly two degrees fall on either side of the threshold in both directions. Hot, cold and limit-equal samples are also reachable with small, readable numbers. Later tests reprogram the limits and the threshold, so the comparisons are also exercised against values other than the defaults.

// File: rtl/tmon_pkg.sv
package tmon_pkg;

  localparam int DW = 8;
  localparam int AW = 5;

  localparam logic [AW-1:0] A_TEMP  = 5'h00;
  localparam logic [AW-1:0] A_INTEN = 5'h05;
  localparam logic [AW-1:0] A_STAT  = 5'h07;
  localparam logic [AW-1:0] A_CTRL  = 5'h0D;
  localparam logic [AW-1:0] A_HOT   = 5'h10;
  localparam logic [AW-1:0] A_COLD  = 5'h11;
  localparam logic [AW-1:0] A_DELTA = 5'h12;

  localparam int CTRL_START = 7;
  localparam int CTRL_REARM = 6;

  // Status bits, bit 0 (eoc) to bit 4 (err).
  typedef struct packed {
    logic err;
    logic cold;
    logic hot;
    logic dtx;
    logic eoc;
  } stat_t;

  localparam int SW = $bits(stat_t);

  typedef enum logic {SQ_IDLE, SQ_WAIT} sq_state_e;

endpackage

// File: rtl/tmon_seq.sv
module tmon_seq
  import tmon_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          adc_valid,
  input  logic [DW-1:0] adc_data,
  output logic          adc_start,
  output logic          adc_ready,
  output logic          busy,
  output logic          start_ack,
  output logic          done,
  output logic [DW-1:0] done_data,
  output logic          tmo
);

  localparam int CW = $clog2(TIMEOUT_CYC + 1);

  sq_state_e     state_q;
  logic [CW-1:0] wait_cnt_q;

  assign adc_ready = (state_q == SQ_WAIT);
  assign busy      = (state_q == SQ_WAIT);
  assign start_ack = start_req && (state_q == SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      wait_cnt_q <= '0;
      adc_start  <= 1'b0;
      done       <= 1'b0;
      done_data  <= '0;
      tmo        <= 1'b0;
    end else begin
      adc_start <= 1'b0;
      done      <= 1'b0;
      tmo       <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (start_req) begin
            state_q    <= SQ_WAIT;
            wait_cnt_q <= '0;
            adc_start  <= 1'b1;
          end
        end
        SQ_WAIT: begin
          if (adc_valid) begin
            state_q   <= SQ_IDLE;
            done      <= 1'b1;
            done_data <= adc_data;
          end else if (wait_cnt_q == CW'(TIMEOUT_CYC - 1)) begin
            state_q <= SQ_IDLE;
            tmo     <= 1'b1;
          end else begin
            wait_cnt_q <= wait_cnt_q + 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tmon_eval.sv
module tmon_eval
  import tmon_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic [DW-1:0] sample,
  input  logic          rearm,
  input  logic [DW-1:0] hot_lim,
  input  logic [DW-1:0] cold_lim,
  input  logic [DW-1:0] delta,
  output logic          dtx_hit,
  output logic          hot_hit,
  output logic          cold_hit
);

  logic [DW-1:0]        base_q;
  logic                 base_vld_q;
  logic signed [DW:0]   diff;
  logic [DW:0]          mag;

  always_comb begin
    diff = $signed({sample[DW-1], sample}) - $signed({base_q[DW-1], base_q});
    mag  = diff[DW] ? (~diff + 1'b1) : diff;
  end

  assign dtx_hit  = base_vld_q && (mag >= {1'b0, delta});
  assign hot_hit  = $signed(sample) > $signed(hot_lim);
  assign cold_hit = $signed(sample) < $signed(cold_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q     <= '0;
      base_vld_q <= 1'b0;
    end else if (rearm) begin
      base_vld_q <= 1'b0;
    end else if (done && (!base_vld_q || dtx_hit)) begin
      base_q     <= sample;
      base_vld_q <= 1'b1;
    end
  end

endmodule

// File: rtl/tmon_regs.sv
module tmon_regs
  import tmon_pkg::*;
#(
  parameter logic [DW-1:0] HOT_DEF   = 8'd45,
  parameter logic [DW-1:0] COLD_DEF  = 8'hFB,
  parameter logic [DW-1:0] DELTA_DEF = 8'd2,
  parameter logic [DW-1:0] EN_RST    = 8'h1F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          busy,
  input  logic          start_ack,
  input  logic          done,
  input  logic [DW-1:0] done_data,
  input  logic          tmo,
  input  logic          dtx_hit,
  input  logic          hot_hit,
  input  logic          cold_hit,
  output logic          start_req,
  output logic          rearm,
  output logic [DW-1:0] hot_lim,
  output logic [DW-1:0] cold_lim,
  output logic [DW-1:0] delta,
  output logic          irq_n
);

  logic [DW-1:0] temp_q;
  logic          conv_end_q;
  logic [SW-1:0] en_q;
  stat_t         stat_q, stat_n;
  logic [DW-1:0] rd_mux;
  logic          ctrl_wr, stat_rd;

  assign ctrl_wr   = wr_en && (addr == A_CTRL);
  assign stat_rd   = rd_en && (addr == A_STAT);
  assign start_req = ctrl_wr && wdata[CTRL_START];
  assign rearm     = ctrl_wr && wdata[CTRL_REARM];
  assign irq_n     = ~|(stat_q & en_q);

  always_comb begin
    stat_n = stat_q;
    if (stat_rd) begin
      stat_n.eoc = 1'b0;
      stat_n.dtx = 1'b0;
      stat_n.err = 1'b0;
    end
    if (done) begin
      stat_n.eoc  = 1'b1;
      stat_n.dtx  = stat_n.dtx | dtx_hit;
      stat_n.hot  = hot_hit;
      stat_n.cold = cold_hit;
    end
    if (tmo) stat_n.err = 1'b1;
  end

  always_comb begin
    unique case (addr)
      A_TEMP:  rd_mux = temp_q;
      A_INTEN: rd_mux = {{(DW-SW){1'b0}}, en_q};
      A_STAT:  rd_mux = {{(DW-SW){1'b0}}, stat_q};
      A_CTRL:  rd_mux = {busy, 1'b0, conv_end_q, 5'b0};
      A_HOT:   rd_mux = hot_lim;
      A_COLD:  rd_mux = cold_lim;
      A_DELTA: rd_mux = delta;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q     <= '0;
      conv_end_q <= 1'b0;
      en_q       <= EN_RST[SW-1:0];
      stat_q     <= '0;
      hot_lim    <= HOT_DEF;
      cold_lim   <= COLD_DEF;
      delta      <= DELTA_DEF;
      rdata      <= '0;
    end else begin
      stat_q <= stat_n;
      rdata  <= rd_en ? rd_mux : '0;
      if (done) temp_q <= done_data;
      if (start_ack)  conv_end_q <= 1'b0;
      else if (done)  conv_end_q <= 1'b1;
      if (wr_en) begin
        unique case (addr)
          A_INTEN: en_q     <= wdata[SW-1:0];
          A_HOT:   hot_lim  <= wdata;
          A_COLD:  cold_lim <= wdata;
          A_DELTA: delta    <= wdata;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/tmon_ctrl.sv
module tmon_ctrl
  import tmon_pkg::*;
#(
  parameter int            TIMEOUT_CYC = 1024,
  parameter logic [DW-1:0] HOT_DEF     = 8'd45,
  parameter logic [DW-1:0] COLD_DEF    = 8'hFB,
  parameter logic [DW-1:0] DELTA_DEF   = 8'd2,
  parameter logic [DW-1:0] EN_RST      = 8'h1F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic          reg_rd_en,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          adc_start,
  output logic          adc_ready,
  input  logic          adc_valid,
  input  logic [DW-1:0] adc_data,
  output logic          irq_n
);

  logic          start_req, start_ack, busy, done, tmo, rearm;
  logic [DW-1:0] done_data, hot_lim, cold_lim, delta;
  logic          dtx_hit, hot_hit, cold_hit;

  tmon_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .adc_valid (adc_valid),
    .adc_data  (adc_data),
    .adc_start (adc_start),
    .adc_ready (adc_ready),
    .busy      (busy),
    .start_ack (start_ack),
    .done      (done),
    .done_data (done_data),
    .tmo       (tmo)
  );

  tmon_eval u_eval (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .sample   (done_data),
    .rearm    (rearm),
    .hot_lim  (hot_lim),
    .cold_lim (cold_lim),
    .delta    (delta),
    .dtx_hit  (dtx_hit),
    .hot_hit  (hot_hit),
    .cold_hit (cold_hit)
  );

  tmon_regs #(
    .HOT_DEF   (HOT_DEF),
    .COLD_DEF  (COLD_DEF),
    .DELTA_DEF (DELTA_DEF),
    .EN_RST    (EN_RST)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .rd_en     (reg_rd_en),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .busy      (busy),
    .start_ack (start_ack),
    .done      (done),
    .done_data (done_data),
    .tmo       (tmo),
    .dtx_hit   (dtx_hit),
    .hot_hit   (hot_hit),
    .cold_hit  (cold_hit),
    .start_req (start_req),
    .rearm     (rearm),
    .hot_lim   (hot_lim),
    .cold_lim  (cold_lim),
    .delta     (delta),
    .irq_n     (irq_n)
  );

endmodule

// File: rtl/tmon_ctrl_chk.sv
module tmon_ctrl_chk
  import tmon_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1024
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr_en,
  input logic [AW-1:0] reg_addr,
  input logic          start_bit,
  input logic [SW-1:0] en_bits,
  input logic          adc_start,
  input logic          adc_ready,
  input logic          adc_valid,
  input logic          irq_n
);

  localparam int RW = $clog2(TIMEOUT_CYC + 2);

  logic [RW-1:0] ready_run_q;
  logic          start_wr, en_zero_wr;

  assign start_wr   = reg_wr_en && (reg_addr == A_CTRL) && start_bit;
  assign en_zero_wr = reg_wr_en && (reg_addr == A_INTEN) && (en_bits == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ready_run_q <= '0;
    else if (!adc_ready)     ready_run_q <= '0;
    else if (ready_run_q != '1) ready_run_q <= ready_run_q + 1'b1;
  end

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  assert_start_with_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> adc_ready);

  assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> $past(start_wr));

  assert_accept_drops_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_ready && adc_valid) |=> !adc_ready);

  assert_mask_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en_zero_wr |=> irq_n);

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_ready && start_wr) |=> !adc_start);

  assert_wait_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ready_run_q <= RW'(TIMEOUT_CYC));

endmodule

bind tmon_ctrl tmon_ctrl_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .start_bit (reg_wdata[7]),
  .en_bits   (reg_wdata[4:0]),
  .adc_start (adc_start),
  .adc_ready (adc_ready),
  .adc_valid (adc_valid),
  .irq_n     (irq_n)
);

// File: tb/tb_tmon_ctrl.sv
module tb_tmon_ctrl;
  import tmon_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          adc_start, adc_ready, irq_n;
  logic          adc_valid = 1'b0;
  logic [DW-1:0] adc_data = '0;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmon_ctrl #(
    .TIMEOUT_CYC (TMO),
    .HOT_DEF     (8'd40),
    .COLD_DEF    (8'hFB),
    .DELTA_DEF   (8'd2),
    .EN_RST      (8'h1F)
  ) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .adc_start(adc_start), .adc_ready(adc_ready), .adc_valid(adc_valid),
    .adc_data(adc_data), .irq_n(irq_n)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic feed(input logic [7:0] v);
    adc_valid = 1'b1; adc_data = v;
    @(negedge clk);
    adc_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic convert(input logic [7:0] v);
    wr(A_CTRL, 8'h80);
    feed(v);
  endtask

  task automatic conv_stat(input string tag, input logic [7:0] v, input logic [7:0] exp);
    logic [7:0] d;
    convert(v);
    rd(A_STAT, d);
    check(tag, d, exp);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 irq_n", {7'd0, irq_n}, 8'd1);
    check("R1 adc_start", {7'd0, adc_start}, 8'd0);
    check("R1 adc_ready", {7'd0, adc_ready}, 8'd0);
    rd(A_INTEN, d); check("R1 enables", d, 8'h1F);
    rd(A_HOT, d);   check("R1 hot limit", d, 8'd40);
    rd(A_COLD, d);  check("R1 cold limit", d, 8'hFB);
    rd(A_DELTA, d); check("R1 delta", d, 8'd2);
    rd(A_CTRL, d);  check("R1 ctrl", d, 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] d;
    wr(A_CTRL, 8'h80);
    check("R2 ready after start", {7'd0, adc_ready}, 8'd1);
    rd(A_CTRL, d); check("R2 busy, conv_end clear", d, 8'h80);
    check("R3 still waiting without valid", {7'd0, adc_ready}, 8'd1);
    feed(8'd25);
    check("R3 ready dropped", {7'd0, adc_ready}, 8'd0);
    rd(A_TEMP, d); check("R4 readout", d, 8'd25);
    rd(A_CTRL, d); check("R4 conv_end set", d, 8'h20);
    check("R8 irq on eoc", {7'd0, irq_n}, 8'd0);
    rd(A_STAT, d); check("R5 first reading no swing", d, 8'h01);
    check("R8 irq released after read", {7'd0, irq_n}, 8'd1);
    rd(A_STAT, d); check("R7 cleared by read", d, 8'h00);
    wr(A_TEMP, 8'h55);
    rd(A_TEMP, d); check("R11 readout write ignored", d, 8'd25);
    wr(A_STAT, 8'h1F);
    rd(A_STAT, d); check("R11 status write ignored", d, 8'h00);
    rd(5'h1F, d);  check("R11 unmapped reads zero", d, 8'h00);
  endtask

  task automatic t_delta();
    conv_stat("R5 +1 no swing", 8'd26, 8'h01);
    conv_stat("R5 +2 swing", 8'd27, 8'h03);
    conv_stat("R5 -1 vs reloaded base", 8'd26, 8'h01);
    conv_stat("R5 -2 swing", 8'd25, 8'h03);
  endtask

  task automatic t_hot();
    logic [7:0] d;
    conv_stat("R6 hot with swing", 8'd50, 8'h07);
    rd(A_STAT, d); check("R7 hot kept after read", d, 8'h04);
    check("R8 irq held by hot", {7'd0, irq_n}, 8'd0);
    wr(A_INTEN, 8'h1B);
    check("R8 hot mask releases irq", {7'd0, irq_n}, 8'd1);
    rd(A_STAT, d); check("R6 hot visible while masked", d, 8'h04);
    conv_stat("R6 hot recovers", 8'd30, 8'h03);
    wr(A_INTEN, 8'h1F);
  endtask

  task automatic t_cold();
    logic [7:0] d;
    wr(A_INTEN, 8'h00);
    convert(8'hF6);
    check("R8 all masked keeps irq high", {7'd0, irq_n}, 8'd1);
    rd(A_STAT, d); check("R6 cold at -10", d, 8'h0B);
    rd(A_STAT, d); check("R7 cold kept", d, 8'h08);
    conv_stat("R6 cold at limit clears", 8'hFB, 8'h03);
    rd(A_TEMP, d); check("R4 signed readout", d, 8'hFB);
    wr(A_INTEN, 8'h1F);
  endtask

  task automatic t_busy_timeout();
    logic [7:0] d;
    wr(A_CTRL, 8'h80);
    repeat (4) @(negedge clk);
    wr(A_CTRL, 8'h80);
    repeat (TMO - 5) @(negedge clk);
    rd(A_CTRL, d); check("R9 R10 second start ignored, wait ended", d, 8'h00);
    check("R10 ready low after timeout", {7'd0, adc_ready}, 8'd0);
    check("R10 irq on error", {7'd0, irq_n}, 8'd0);
    rd(A_STAT, d); check("R10 error bit", d, 8'h10);
    rd(A_TEMP, d); check("R10 readout unchanged", d, 8'hFB);
  endtask

  task automatic t_rearm();
    wr(A_CTRL, 8'h40);
    conv_stat("R5 re-arm takes new base", 8'd80, 8'h05);
    conv_stat("R5 small step after re-arm", 8'd81, 8'h05);
  endtask

  task automatic t_limits();
    logic [7:0] d;
    wr(A_HOT, 8'd100);
    rd(A_HOT, d); check("R6 hot limit written", d, 8'd100);
    conv_stat("R6 below new hot limit", 8'd90, 8'h03);
    wr(A_DELTA, 8'd20);
    conv_stat("R5 wider threshold, equal hot", 8'd100, 8'h01);
    conv_stat("R6 above new hot limit", 8'd101, 8'h05);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_delta();
    t_hot();
    t_cold();
    t_busy_timeout();
    t_rearm();
    t_limits();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule